// File: doc/BRIEF.md
# Mixed-Width Immediate Fetch Controller

This block sits in the front end of a processor that runs in two memory modes. One is a 16-bit compatibility mode. The other is a 24-bit linear-address mode.

For each instruction the decoder hands the block one request. The request carries either an explicit two-part width override or nothing, in which case a single mode bit supplies both parts. The data part chooses between a 16-bit and a 24-bit data path. Under the 16-bit choice, an 8-bit base register fills the upper address byte. The stream part chooses whether an instruction of ambiguous length carries two or three immediate bytes. The decoder can also give a fixed length that overrides the stream part.

The block pulls the immediate bytes one per cycle from a byte-wide valid/ready stream, least significant byte first, and assembles them. It then reports the assembled value, the 24-bit effective address and an operand-width flag with a single-cycle completion pulse.

Top module: `imm_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block is cleared: `done`=0, `req_ready`=1, `byte_ready`=0, `imm_out`=0, `eff_addr`=0, `wide`=0.
- R2: When `sfx_present`=0, both parts follow `mode_long`. A value of 1 selects the 24-bit data part and the 3-byte stream part. A value of 0 selects the 16-bit data part and the 2-byte stream part.
- R3: With `len_fixed`=0 and the resolved stream part short (`sfx_stream_long`=0 when a suffix is present), exactly 2 bytes are fetched. `imm_out[23:16]` is 0.
- R4: With `len_fixed`=0 and the resolved stream part long, exactly 3 bytes are fetched.
- R5: With `len_fixed`=1, exactly `fixed_len` bytes (0 to 3) are fetched, whatever the stream part says. A zero-length request completes without fetching any byte.
- R6: With the resolved data part short (`sfx_data_long`=0 when a suffix is present), `wide`=0 and `eff_addr` = {base, `imm_out[15:0]`}. The base is the `base_reg` value sampled when the request was accepted.
- R7: With the resolved data part long, `wide`=1 and `eff_addr` = `imm_out`. `base_reg` has no effect.
- R8: A byte is consumed only in a cycle where `byte_valid` and `byte_ready` are both 1. The k-th consumed byte (k from 0) lands in `imm_out[8k+7:8k]`. Stall cycles and bytes offered while idle are not consumed.
- R9: `done` is high for exactly one cycle. For a fetch it rises the cycle after the last byte is consumed. For a zero-length request it rises the second cycle after acceptance. `imm_out`, `eff_addr` and `wide` hold their values until the next `done`.
- R10: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a fetch is in progress and in the `done` cycle. A request offered then is ignored. All mode and length inputs are sampled at acceptance.
- R11: A reset in the middle of a fetch abandons it. The next request assembles only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New instruction request |
| req_ready | output | 1 | Block idle, request can be taken |
| sfx_present | input | 1 | Explicit width override given |
| sfx_data_long | input | 1 | Override data part: 1 = 24-bit, 0 = 16-bit with base |
| sfx_stream_long | input | 1 | Override stream part: 1 = 3 bytes, 0 = 2 bytes |
| mode_long | input | 1 | Default mode bit when no override |
| len_fixed | input | 1 | Decoder gives an unambiguous length |
| fixed_len | input | 2 | Unambiguous byte count, 0 to 3 |
| base_reg | input | 8 | Upper address byte for the 16-bit data part |
| byte_valid | input | 1 | Stream byte available |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Block consumes a byte this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| imm_out | output | 24 | Assembled immediate, zero-extended |
| eff_addr | output | 24 | Effective address |
| wide | output | 1 | 1 = 24-bit operand, 0 = 16-bit |

## Verification
On every cycle, the embedded assertions check the following. `done` is a single-cycle pulse. The byte counter stays below the target. A short fetch zero-extends. Outputs hold between completions. On completion, the address relates to the immediate as the width flag demands.

Only the bench's scenarios can show the rest. These are the resolution of the four override combinations and the default mode, the byte counts actually consumed, the byte order under stalls, the sampling of base and mode at acceptance, ignored requests while busy, and recovery after a mid-fetch reset.

// File: rtl/imm_fetch_pkg.sv
// Package: shared types for the immediate fetch controller.
// Assumes: the controller never needs more than three fetch states.
package imm_fetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMPTY = 2'd2
    } fetch_state_e;

    // Pick the override part when present, otherwise the default mode bit.
    function automatic logic pick_part(input logic present, input logic ovr, input logic dflt);
        return present ? ovr : dflt;
    endfunction

endpackage

// File: rtl/imm_mode_decode.sv
// Module: imm_mode_decode
// Resolves the data part and stream part of a request, then the byte count.
// Assumes: purely combinational; the caller samples the outputs at acceptance.
module imm_mode_decode #(
    parameter int ADDR_W  = 24,
    parameter int BYTE_W  = 8,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 2
) (
    input  logic             sfx_present,
    input  logic             sfx_data_long,
    input  logic             sfx_stream_long,
    input  logic             mode_long,
    input  logic             len_fixed,
    input  logic [CNT_W-1:0] fixed_len,
    output logic             data_long,
    output logic [CNT_W-1:0] byte_count
);
    import imm_fetch_pkg::*;

    localparam int SHORT_BYTES = SHORT_W / BYTE_W;
    localparam int LONG_BYTES  = ADDR_W / BYTE_W;

    logic stream_long;

    // Resolve both parts and the byte count for this request.
    always_comb begin
        data_long   = pick_part(sfx_present, sfx_data_long, mode_long);
        stream_long = pick_part(sfx_present, sfx_stream_long, mode_long);
        if (len_fixed)
            byte_count = fixed_len;
        else if (stream_long)
            byte_count = CNT_W'(LONG_BYTES);
        else
            byte_count = CNT_W'(SHORT_BYTES);
    end

endmodule

// File: rtl/imm_byte_collector.sv
// Module: imm_byte_collector
// Consumes stream bytes one per cycle and assembles them least significant first.
// Assumes: req_take only while req_ready; byte_count never exceeds NBYTES.
module imm_byte_collector #(
    parameter int BYTE_W  = 8,
    parameter int NBYTES  = 3,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_take,
    input  logic [CNT_W-1:0]         byte_count,
    input  logic                     byte_valid,
    input  logic [BYTE_W-1:0]        byte_data,
    output logic                     byte_ready,
    output logic                     req_ready,
    output logic                     finish,
    output logic [NBYTES*BYTE_W-1:0] value_next,
    output logic                     done,
    output logic [NBYTES*BYTE_W-1:0] imm_q
);
    import imm_fetch_pkg::*;

    localparam int VAL_W       = NBYTES * BYTE_W;
    localparam int SHORT_BYTES = SHORT_W / BYTE_W;

    fetch_state_e                   state_q;
    logic [CNT_W-1:0]               cnt_q;
    logic [CNT_W-1:0]               tgt_q;
    logic [NBYTES-1:0][BYTE_W-1:0]  lane_q;
    logic [NBYTES-1:0][BYTE_W-1:0]  lane_next;
    logic                           take_byte;
    logic                           last_byte;
    logic                           done_q;

    // Handshake qualifiers for the current cycle.
    always_comb begin
        take_byte  = (state_q == ST_FETCH) && byte_valid;
        last_byte  = take_byte && (cnt_q == CNT_W'(tgt_q - 1'b1));
        finish     = last_byte || (state_q == ST_EMPTY);
        byte_ready = (state_q == ST_FETCH);
        req_ready  = (state_q == ST_IDLE) && !done_q;
    end

    // One lane per byte position: each lane captures its own byte index.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        // Merge the byte arriving this cycle into its lane.
        always_comb begin
            lane_next[i] = (take_byte && cnt_q == CNT_W'(i)) ? byte_data : lane_q[i];
        end

        // Lane storage, cleared on reset and on each accepted request.
        always_ff @(posedge clk) begin
            if (!rst_n || req_take)
                lane_q[i] <= '0;
            else
                lane_q[i] <= lane_next[i];
        end
    end

    assign value_next = VAL_W'(lane_next);

    // Fetch sequencing: idle, fetching, or a zero-length completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else if (req_take) begin
            state_q <= (byte_count == '0) ? ST_EMPTY : ST_FETCH;
            cnt_q   <= '0;
            tgt_q   <= byte_count;
        end else if (finish) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (take_byte) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Completion pulse and the held result value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            imm_q  <= '0;
        end else begin
            done_q <= finish;
            if (finish)
                imm_q <= value_next;
        end
    end

    assign done = done_q;

    // R9: the completion pulse never lasts two cycles.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: the byte counter stays below the target while fetching.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (cnt_q < tgt_q));

    // R3: a short fetch leaves the upper bytes zero.
    p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && tgt_q <= CNT_W'(SHORT_BYTES)) |-> (imm_q[VAL_W-1:SHORT_W] == '0));

    // R10: the target does not change while a fetch is in progress.
    p_tgt_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && $past(state_q == ST_FETCH)) |-> $stable(tgt_q));

endmodule

// File: rtl/imm_addr_former.sv
// Module: imm_addr_former
// Samples the data part and base at acceptance; forms the effective address at completion.
// Assumes: finish and value come from the collector in the same cycle.
module imm_addr_former #(
    parameter int ADDR_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_take,
    input  logic              data_long,
    input  logic [ADDR_W-SHORT_W-1:0] base_reg,
    input  logic              finish,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wide
);
    localparam int BASE_W = ADDR_W - SHORT_W;

    logic              long_q;
    logic [BASE_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wide_q;

    // Capture the data part and base when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_q <= 1'b0;
            base_q <= '0;
        end else if (req_take) begin
            long_q <= data_long;
            base_q <= base_reg;
        end
    end

    // Form the address and width flag on completion; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wide_q <= 1'b0;
        end else if (finish) begin
            addr_q <= long_q ? value : {base_q, value[SHORT_W-1:0]};
            wide_q <= long_q;
        end
    end

    assign eff_addr = addr_q;
    assign wide     = wide_q;

    // R9: address and width hold between completions.
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(addr_q) && $stable(wide_q)));

endmodule

// File: rtl/imm_fetch_ctrl.sv
// Module: imm_fetch_ctrl (top)
// Resolves the width override, fetches the immediate bytes and forms the address.
// Assumes: ADDR_W and SHORT_W are whole multiples of BYTE_W.
module imm_fetch_ctrl #(
    parameter int ADDR_W  = 24,
    parameter int SHORT_W = 16,
    parameter int BYTE_W  = 8,
    localparam int NBYTES = ADDR_W / BYTE_W,
    localparam int CNT_W  = $clog2(NBYTES + 1),
    localparam int BASE_W = ADDR_W - SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              sfx_present,
    input  logic              sfx_data_long,
    input  logic              sfx_stream_long,
    input  logic              mode_long,
    input  logic              len_fixed,
    input  logic [CNT_W-1:0]  fixed_len,
    input  logic [BASE_W-1:0] base_reg,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    output logic              done,
    output logic [ADDR_W-1:0] imm_out,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wide
);
    logic              data_long;
    logic [CNT_W-1:0]  byte_count;
    logic              req_take;
    logic              finish;
    logic [ADDR_W-1:0] value_next;

    // A request is taken only when offered and the block is ready.
    assign req_take = req_valid && req_ready;

    imm_mode_decode #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .SHORT_W(SHORT_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .sfx_present    (sfx_present),
        .sfx_data_long  (sfx_data_long),
        .sfx_stream_long(sfx_stream_long),
        .mode_long      (mode_long),
        .len_fixed      (len_fixed),
        .fixed_len      (fixed_len),
        .data_long      (data_long),
        .byte_count     (byte_count)
    );

    imm_byte_collector #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES),
        .SHORT_W(SHORT_W),
        .CNT_W  (CNT_W)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_take  (req_take),
        .byte_count(byte_count),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_ready(byte_ready),
        .req_ready (req_ready),
        .finish    (finish),
        .value_next(value_next),
        .done      (done),
        .imm_q     (imm_out)
    );

    imm_addr_former #(
        .ADDR_W (ADDR_W),
        .SHORT_W(SHORT_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_take (req_take),
        .data_long(data_long),
        .base_reg (base_reg),
        .finish   (finish),
        .value    (value_next),
        .eff_addr (eff_addr),
        .wide     (wide)
    );

    // R7: a wide result uses the immediate as the address unchanged.
    p_wide_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wide) |-> (eff_addr == imm_out));

    // R6: a narrow result keeps the immediate's low half as the offset.
    p_narrow_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide) |-> (eff_addr[SHORT_W-1:0] == imm_out[SHORT_W-1:0]));

    // R10: no byte is requested while a new request can be taken.
    p_ready_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_ready && req_ready));

    // R5: the resolved count never exceeds the widest fetch.
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |-> (byte_count <= CNT_W'(NBYTES)));

endmodule

// File: tb/imm_fetch_ctrl_test.sv
module imm_fetch_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        sfx_present = 1'b0;
    logic        sfx_data_long = 1'b0;
    logic        sfx_stream_long = 1'b0;
    logic        mode_long = 1'b0;
    logic        len_fixed = 1'b0;
    logic [1:0]  fixed_len = 2'd0;
    logic [7:0]  base_reg = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_ready;
    logic        done;
    logic [23:0] imm_out;
    logic [23:0] eff_addr;
    logic        wide;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    imm_fetch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .sfx_present(sfx_present), .sfx_data_long(sfx_data_long),
        .sfx_stream_long(sfx_stream_long), .mode_long(mode_long),
        .len_fixed(len_fixed), .fixed_len(fixed_len), .base_reg(base_reg),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .done(done), .imm_out(imm_out), .eff_addr(eff_addr), .wide(wide)
    );

    // Vector fields: [89] sfx_present [88] data part [87] stream part [86] mode
    // [85] len_fixed [84:83] fixed_len [82:75] base [74:51] stream bytes {b2,b1,b0}
    // [50:49] expected byte count [48:25] expected imm [24:1] expected addr [0] wide
    localparam int NV = 9;
    localparam logic [89:0] VECS [NV] = '{
        {1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'hA5,24'h332211, 2'd3,24'h332211,24'h332211,1'b1},
        {1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'hA5,24'hCCBBAA, 2'd2,24'h00BBAA,24'hA5BBAA,1'b0},
        {1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,8'h7E,24'h563412, 2'd3,24'h563412,24'h7E3412,1'b0},
        {1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'h7E,24'h998877, 2'd2,24'h008877,24'h008877,1'b1},
        {1'b1,1'b1,1'b1,1'b0,1'b0,2'd0,8'h3C,24'hC0FFEE, 2'd3,24'hC0FFEE,24'hC0FFEE,1'b1},
        {1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,8'h12,24'h445566, 2'd2,24'h005566,24'h125566,1'b0},
        {1'b0,1'b0,1'b0,1'b1,1'b1,2'd1,8'h12,24'h77665A, 2'd1,24'h00005A,24'h00005A,1'b1},
        {1'b1,1'b0,1'b0,1'b1,1'b1,2'd3,8'h0F,24'hABCDEF, 2'd3,24'hABCDEF,24'h0FCDEF,1'b0},
        {1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,8'h44,24'h123456, 2'd0,24'h000000,24'h440000,1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one request: offer it, feed bytes (optionally stalling), check the result.
    task automatic run_vec(input logic [89:0] v, input bit stall, input string tag);
        int n = 0;
        bit got = 1'b0;
        @(negedge clk);
        sfx_present = v[89]; sfx_data_long = v[88]; sfx_stream_long = v[87];
        mode_long = v[86]; len_fixed = v[85]; fixed_len = v[84:83];
        base_reg = v[82:75];
        chk(req_ready == 1'b1, {tag, " R10 ready before accept"}, 32'(req_ready), 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R10/R6: scramble every sampled input after acceptance.
        sfx_present = ~v[89]; sfx_data_long = ~v[88]; sfx_stream_long = ~v[87];
        mode_long = ~v[86]; len_fixed = ~v[85]; fixed_len = ~v[84:83];
        base_reg = ~v[82:75];
        for (int k = 0; k < 16; k++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            if (byte_ready && !(stall && (k % 2 == 1))) begin
                byte_valid = 1'b1;
                byte_data  = 8'(v[74:51] >> (8 * n));
                n++;
            end else begin
                byte_valid = 1'b0;
                byte_data  = 8'hE5;
            end
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk(got, {tag, " R9 done seen"}, 32'(got), 1);
        chk(n == int'(v[50:49]), {tag, " R3/R4/R5 byte count"}, 32'(n), 32'(v[50:49]));
        chk(imm_out == v[48:25], {tag, " R8 imm assembly"}, 32'(imm_out), 32'(v[48:25]));
        chk(eff_addr == v[24:1], {tag, " R6/R7 address"}, 32'(eff_addr), 32'(v[24:1]));
        chk(wide == v[0], {tag, " R2/R6/R7 width"}, 32'(wide), 32'(v[0]));
        chk(req_ready == 1'b0, {tag, " R10 not ready in done cycle"}, 32'(req_ready), 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 single pulse"}, 32'(done), 0);
        chk(imm_out == v[48:25] && eff_addr == v[24:1], {tag, " R9 hold"}, 32'(eff_addr), 32'(v[24:1]));
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(done == 0 && req_ready == 1 && byte_ready == 0, "R1 reset handshake",
            {29'd0, done, req_ready, byte_ready}, 32'b010);
        chk(imm_out == 0 && eff_addr == 0 && wide == 0, "R1 reset outputs",
            32'(eff_addr), 0);
        rst_n = 1'b1;

        // Table walk: R2..R9 across modes, overrides and fixed lengths.
        for (int i = 0; i < NV; i++)
            run_vec(VECS[i], (i % 2) == 1, $sformatf("vec%0d", i));

        // R8: bytes offered while idle are not consumed.
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = 8'hEE;
        repeat (2) @(negedge clk);
        run_vec(VECS[1], 1'b0, "idle_bytes R8");

        // R10: a request offered mid-fetch is ignored.
        @(negedge clk);
        sfx_present = 0; mode_long = 1; len_fixed = 0; base_reg = 8'h55;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        byte_valid = 1; byte_data = 8'h01;
        @(negedge clk);
        byte_valid = 0;
        mode_long = 0; len_fixed = 1; fixed_len = 2'd0; req_valid = 1;
        chk(req_ready == 0, "R10 busy not ready", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 0;
        chk(byte_ready == 1 && done == 0, "R10 busy request ignored", 32'(byte_ready), 1);
        byte_valid = 1; byte_data = 8'h02;
        @(negedge clk);
        byte_data = 8'h03;
        @(negedge clk);
        byte_valid = 0;
        chk(done == 1 && imm_out == 24'h030201, "R10 original fetch completes", 32'(imm_out), 32'h030201);
        @(negedge clk);
        chk(done == 0 && req_ready == 1, "R10 no second completion", 32'(done), 0);

        // R11: reset mid-fetch abandons the partial value.
        sfx_present = 0; mode_long = 1; len_fixed = 0;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        byte_valid = 1; byte_data = 8'h9A;
        @(negedge clk);
        byte_valid = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(req_ready == 1 && byte_ready == 0 && done == 0, "R11 idle after reset",
            {29'd0, done, req_ready, byte_ready}, 32'b010);
        chk(imm_out == 0 && eff_addr == 0, "R1 R11 outputs cleared", 32'(imm_out), 0);
        run_vec(VECS[5], 1'b1, "after_reset R11");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule